// File: doc/BRIEF.md
# Fractional-increment Realtime Counter

This block keeps a free-running master count that advances at a fixed nominal rate, 6.144 MHz, whatever reference clock drives it. It does not add one on every clock. A fractional accumulator adds a programmable step on every clock. Each time the accumulated value reaches a programmable divisor, the count advances by one. Over the long run the count rate is therefore the clock rate times step divided by divisor. For common references the pairs are 64/125 at 12 MHz, 8/25 at 19.2 MHz, 4/25 at 38.4 MHz, 768/1625 at 13 MHz, 384/1625 at 26 MHz, 192/625 at 20 MHz and 256/1125 at 27 MHz. The pair 75/244 applies when the slow reference is derived from the input clock divided by 610.

Local timers take the count straight from a wide output port. Software reaches the block through a simple register port. It can read and write the step and divisor registers. It can read the count as two halves, and the pair stays coherent across a carry.

Top module: `frac_rt_counter`

## Requirements
- R1: After synchronous reset the count, both configuration registers and the read data are all zero. The block then stays idle, because a zero divisor stops counting.
- R2: The step value is the low 12 bits of the register at offset 0x0. The divisor value is the low 12 bits of the register at offset 0x4. When 0 < step < divisor, every clock adds the step to the accumulator. When the sum reaches or passes the divisor, the count advances by one and the divisor is subtracted.
- R3: Starting from a cleared accumulator, exactly divisor clocks advance the count by exactly step. This holds for every supported pair (64/125, 768/1625, 8/25, 192/625, 384/1625, 256/1125, 4/25, 75/244).
- R4: A write to offset 0x0 or 0x4 clears the accumulator, and the count does not advance on that clock. The new value applies from the following clock.
- R5: While the divisor value is zero, the count holds its value.
- R6: While the divisor is nonzero and the step is at least the divisor, the count advances by exactly one on every clock.
- R7: Both configuration registers store all 32 written bits and read them back unchanged. The upper 20 bits have no effect on the count rate.
- R8: A read takes effect at the clock edge, and its data shows on rdData from that edge on; rdData holds between reads. A read at offset 0x8 returns the low half of the count and at the same edge copies the high half into a shadow. A read at offset 0xC returns that shadow. Any other offset reads as zero.
- R9: The count advances by at most one per clock. The carry out of the low half reaches the high half on the same clock.
- R10: countOut carries the live count on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register byte offset |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| countOut | output | CNT_W | Live master count for local timers |

## Verification
The hardest case to reach is a split read that spans the carry from the low half into the high half. With a 64-bit count that carry comes about four billion increments after reset. The bench therefore builds the block with a 24-bit count, so each half is 12 bits wide. It programs a step equal to the divisor, waits until the low half shows all ones, and issues the low-half read on exactly the edge where the carry happens. It then checks that the following high-half read returns the value from before the carry. The clear-on-write rule is reached by rewriting the divisor with its own value partway through accumulation, at a point where a remainder carried over would have produced an increment.

// File: rtl/frac_rt_pkg.sv
package frac_rt_pkg;
  localparam int REG_W   = 32;
  localparam int FIELD_W = 12;

  localparam int OFS_STEP   = 'h0;
  localparam int OFS_DIV    = 'h4;
  localparam int OFS_CNT_LO = 'h8;
  localparam int OFS_CNT_HI = 'hC;

  typedef struct packed {
    logic cfgClear;
    logic loRd;
  } dpStrobes_t;
endpackage

// File: rtl/frac_rt_ctrl.sv
module frac_rt_ctrl
  import frac_rt_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   wrData,
  input  logic [CNT_W/2-1:0] cntLo,
  input  logic [CNT_W/2-1:0] hiShadow,
  output logic [FIELD_W-1:0] stepVal,
  output logic [FIELD_W-1:0] divVal,
  output dpStrobes_t         strb,
  output logic [REG_W-1:0]   rdData
);
  localparam int HALF_W = CNT_W / 2;

  logic [REG_W-1:0] stepReg;
  logic [REG_W-1:0] divReg;
  logic selStep, selDiv, selLo, selHi;

  assign selStep = (addr == ADDR_W'(OFS_STEP));
  assign selDiv  = (addr == ADDR_W'(OFS_DIV));
  assign selLo   = (addr == ADDR_W'(OFS_CNT_LO));
  assign selHi   = (addr == ADDR_W'(OFS_CNT_HI));

  always_ff @(posedge clk) begin
    if (rst) begin
      stepReg <= '0;
      divReg  <= '0;
    end else if (wrEn) begin
      if (selStep) stepReg <= wrData;
      if (selDiv)  divReg  <= wrData;
    end
  end

  assign stepVal       = stepReg[FIELD_W-1:0];
  assign divVal        = divReg[FIELD_W-1:0];
  assign strb.cfgClear = wrEn && (selStep || selDiv);
  assign strb.loRd     = rdEn && selLo;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (rdEn) begin
      if (selStep)     rdData <= stepReg;
      else if (selDiv) rdData <= divReg;
      else if (selLo)  rdData <= REG_W'(cntLo);
      else if (selHi)  rdData <= REG_W'(hiShadow);
      else             rdData <= '0;
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> $stable(rdData)); // R8
  AST_CFG_KEEPS_ALL_BITS: assert property (@(posedge clk) disable iff (rst)
    (wrEn && selDiv) |=> (divReg == $past(wrData))); // R7

  initial begin
    assert (HALF_W <= REG_W && CNT_W % 2 == 0) else $error("count width unsupported");
  end
endmodule

// File: rtl/frac_rt_datapath.sv
module frac_rt_datapath
  import frac_rt_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  dpStrobes_t         strb,
  input  logic [FIELD_W-1:0] stepVal,
  input  logic [FIELD_W-1:0] divVal,
  output logic [CNT_W-1:0]   cnt,
  output logic [CNT_W/2-1:0] hiShadow
);
  localparam int HALF_W = CNT_W / 2;
  localparam int SUM_W  = FIELD_W + 1;

  logic [FIELD_W-1:0] acc;
  logic [FIELD_W-1:0] accNext;
  logic [SUM_W-1:0]   sum;
  logic               cntInc;

  assign sum = {1'b0, acc} + {1'b0, stepVal};

  always_comb begin
    accNext = acc;
    cntInc  = 1'b0;
    if (strb.cfgClear) begin
      accNext = '0;
    end else if (divVal == '0) begin
      accNext = acc;
    end else if (stepVal >= divVal) begin
      accNext = '0;
      cntInc  = 1'b1;
    end else if (sum >= {1'b0, divVal}) begin
      accNext = FIELD_W'(sum - {1'b0, divVal});
      cntInc  = 1'b1;
    end else begin
      accNext = sum[FIELD_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      cnt <= '0;
    end else begin
      acc <= accNext;
      if (cntInc) cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            hiShadow <= '0;
    else if (strb.loRd) hiShadow <= cnt[CNT_W-1:HALF_W];
  end

  AST_ACC_BELOW_DIV: assert property (@(posedge clk) disable iff (rst)
    (divVal != '0) |-> (acc < divVal)); // R2
  AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1))); // R9
  AST_CLEAR_NO_INC: assert property (@(posedge clk) disable iff (rst)
    strb.cfgClear |=> (cnt == $past(cnt) && acc == '0)); // R4
  AST_ZERO_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
    (divVal == '0 && !strb.cfgClear) |=> $stable(cnt)); // R5
  AST_FULL_RATE: assert property (@(posedge clk) disable iff (rst)
    (divVal != '0 && stepVal >= divVal && !strb.cfgClear) |=> (cnt == $past(cnt) + CNT_W'(1))); // R6
  AST_SHADOW_ON_LO: assert property (@(posedge clk) disable iff (rst)
    strb.loRd |=> (hiShadow == $past(cnt[CNT_W-1:HALF_W]))); // R8
endmodule

// File: rtl/frac_rt_counter.sv
module frac_rt_counter
  import frac_rt_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic [CNT_W-1:0]  countOut
);
  localparam int HALF_W = CNT_W / 2;

  dpStrobes_t         strb;
  logic [FIELD_W-1:0] stepVal;
  logic [FIELD_W-1:0] divVal;
  logic [CNT_W-1:0]   cnt;
  logic [HALF_W-1:0]  hiShadow;

  frac_rt_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .cntLo(cnt[HALF_W-1:0]), .hiShadow(hiShadow),
    .stepVal(stepVal), .divVal(divVal), .strb(strb), .rdData(rdData)
  );

  frac_rt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .stepVal(stepVal), .divVal(divVal),
    .cnt(cnt), .hiShadow(hiShadow)
  );

  assign countOut = cnt; // R10
endmodule

// File: tb/frac_rt_counter_bench.sv
module frac_rt_counter_bench;
  localparam int CW = 24;
  localparam int HW = CW / 2;
  localparam longint CMASK = (64'd1 << CW) - 1;
  localparam longint LMASK = (64'd1 << HW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [CW-1:0] countOut;

  int checks = 0;
  int failures = 0;

  frac_rt_counter #(.CNT_W(CW), .ADDR_W(4)) u_frac_rt_counter (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .countOut(countOut)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  longint mStep = 0, mDiv = 0, mAcc = 0, mCnt = 0, mShadow = 0, mRd = 0;
  always @(posedge clk) begin
    if (rst) begin
      mStep = 0; mDiv = 0; mAcc = 0; mCnt = 0; mShadow = 0; mRd = 0;
    end else begin
      longint n, d;
      if (rdEn) begin
        case (addr)
          4'h0: mRd = mStep;
          4'h4: mRd = mDiv;
          4'h8: begin mRd = mCnt & LMASK; mShadow = (mCnt >> HW) & LMASK; end
          4'hC: mRd = mShadow;
          default: mRd = 0;
        endcase
      end
      n = mStep & 'hFFF;
      d = mDiv & 'hFFF;
      if (wrEn && (addr == 4'h0 || addr == 4'h4)) begin
        if (addr == 4'h0) mStep = wrData; else mDiv = wrData;
        mAcc = 0;
      end else if (d != 0) begin
        if (n >= d) begin
          mCnt++; mAcc = 0;
        end else begin
          mAcc += n;
          if (mAcc >= d) begin mCnt++; mAcc -= d; end
        end
      end
      mCnt &= CMASK;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(longint'(countOut) == mCnt, "R10 live count vs model", longint'(countOut), mCnt);
      check(longint'(rdData) == mRd, "R8 read data vs model", longint'(rdData), mRd);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] v);
    wrEn = 1'b1; addr = a; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  initial begin
    #(4 * 190000);
    failures++;
    $display("FAIL watchdog expired (R1 run incomplete) actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v, lo, hi;
    longint c0, h0;
    int stepTab[8] = '{64, 768, 8, 192, 384, 256, 4, 75};
    int divTab[8]  = '{125, 1625, 25, 625, 1625, 1125, 25, 244};

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(countOut == '0, "R1 count after reset", longint'(countOut), 0);
    check(rdData == '0, "R1 rdData after reset", longint'(rdData), 0);
    repeat (10) @(negedge clk);
    check(countOut == '0, "R1 idle with zero divisor", longint'(countOut), 0);
    rd(4'h4, v);
    check(v == '0, "R1 divisor register reset", longint'(v), 0);

    // R2: step 1 of 3
    wr(4'h0, 32'd1); wr(4'h4, 32'd3);
    c0 = longint'(countOut);
    repeat (2) @(negedge clk);
    check(longint'(countOut) - c0 == 0, "R2 no advance before divisor reached", longint'(countOut) - c0, 0);
    @(negedge clk);
    check(longint'(countOut) - c0 == 1, "R2 advance on third clock", longint'(countOut) - c0, 1);

    // R3: all supported pairs
    for (int i = 0; i < 8; i++) begin
      wr(4'h0, 32'(stepTab[i])); wr(4'h4, 32'(divTab[i]));
      c0 = longint'(countOut);
      repeat (divTab[i]) @(negedge clk);
      check(longint'(countOut) - c0 == stepTab[i], "R3 exact rate over one divisor window",
            longint'(countOut) - c0, stepTab[i]);
    end

    // R4: rewrite divisor mid accumulation
    wr(4'h0, 32'd2); wr(4'h4, 32'd3);
    c0 = longint'(countOut);
    @(negedge clk);
    wr(4'h4, 32'd3);
    check(longint'(countOut) - c0 == 0, "R4 no advance on write clock", longint'(countOut) - c0, 0);
    @(negedge clk);
    check(longint'(countOut) - c0 == 0, "R4 remainder cleared by write", longint'(countOut) - c0, 0);

    // R5: zero divisor holds
    wr(4'h4, 32'd0);
    c0 = longint'(countOut);
    repeat (50) @(negedge clk);
    check(longint'(countOut) == c0, "R5 count holds with zero divisor", longint'(countOut), c0);

    // R6: step at or above divisor
    wr(4'h0, 32'd5); wr(4'h4, 32'd3);
    c0 = longint'(countOut);
    repeat (20) @(negedge clk);
    check(longint'(countOut) - c0 == 20, "R6 one per clock when step above divisor", longint'(countOut) - c0, 20);
    wr(4'h4, 32'd5);
    c0 = longint'(countOut);
    repeat (7) @(negedge clk);
    check(longint'(countOut) - c0 == 7, "R6 one per clock when step equals divisor", longint'(countOut) - c0, 7);

    // R7: upper bits kept, ignored by rate
    wr(4'h0, 32'hABCDE040); wr(4'h4, 32'h1234507D);
    c0 = longint'(countOut);
    repeat (125) @(negedge clk);
    check(longint'(countOut) - c0 == 64, "R7 upper bits ignored by rate", longint'(countOut) - c0, 64);
    rd(4'h0, v);
    check(v == 32'hABCDE040, "R7 step register readback", longint'(v), 32'hABCDE040);
    rd(4'h4, v);
    check(v == 32'h1234507D, "R7 divisor register readback", longint'(v), 32'h1234507D);

    // R8: unmapped offset
    rd(4'h2, v);
    check(v == '0, "R8 unmapped offset reads zero", longint'(v), 0);

    // R9/R8: split read across the low-half carry
    wr(4'h0, 32'd1); wr(4'h4, 32'd1);
    while (countOut[HW-1:0] != {HW{1'b1}}) @(negedge clk);
    h0 = longint'(countOut[CW-1:HW]);
    rd(4'h8, lo);
    check(longint'(countOut[CW-1:HW]) == ((h0 + 1) & LMASK), "R9 carry into high half",
          longint'(countOut[CW-1:HW]), (h0 + 1) & LMASK);
    check(longint'(lo) == LMASK, "R8 low half read at carry", longint'(lo), LMASK);
    rd(4'hC, hi);
    check(longint'(hi) == h0, "R8 high half coherent with low read", longint'(hi), h0);

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule